// File: doc/BRIEF.md
# Clock Frequency Readback Decoder

This block works out the running frequency, in kHz, of one clock domain from a snapshot of the words that configure it. The caller presents the crystal frequency, the two VCO frequencies and the configuration words (source select, VCO divider control, PLL control, PLL coefficients, final-stage select and final post-divider), then pulses `start_i`. All of them are captured on that edge, so the live inputs may change while the block is working.

The block decodes a source frequency: a fixed reference, or a VCO through an integer divider. It then takes either that source directly or a PLL fed from it or from the crystal. Last it applies an optional post-divider whose formula doubles the numerator. All four divisions share one radix-2 sequential divider. The result appears on `freq_khz_o` together with a one-cycle `done_o` pulse, and it stays there until the next result.

Top module: `clk_readback_decoder`

## Requirements
- R1: On the PLL path (`path_pll_i` = 1), a PLL control word with bit 0 clear gives a result of 0, whatever the post-divider holds.
- R2: Source-select bits 1:0 = 0 gives the crystal frequency, except when bits 17 and 16 are both 1, which gives 108000 kHz; one of those two bits alone still gives the crystal.
- R3: Source-select bits 1:0 = 2 gives 100000 kHz, and = 1 gives 0.
- R4: Source-select bits 1:0 = 3 takes VCO 1 when source bit 8 is 1 and VCO 0 otherwise, and divides twice that VCO frequency by the VCO divider; the divider is 2 when divider-control bit 31 is 0.
- R5: With divider-control bit 31 set, the VCO divider is the 6-bit field at bits 13:8 (when source bit 8 is 1) or bits 5:0 (otherwise), plus 2.
- R6: `path_pll_i` = 1 selects the PLL output and post-divider field bits 13:8; `path_pll_i` = 0 selects the decoded source and field bits 5:0.
- R7: The coefficient word holds P in bits 21:16, N in 15:8 and M in 7:0. The PLL output is ref·N/M/P with integer truncation after each division, kept at full width until the final result. Its reference is the decoded source when `pll_ref_xtal_i` = 0.
- R8: With `pll_ref_xtal_i` = 1 the PLL reference is the crystal and P is taken as 1, whatever bits 21:16 hold.
- R9: An M or P of zero makes the PLL output 0.
- R10: When post-divider bit 31 is set the result is 2·f/(field+2); when it is clear, f passes through unchanged whatever the field bits hold.
- R11: `done_o` is high for exactly one cycle, 4·(FREQ_W+11) rising edges after the edge that samples `start_i` (172 at defaults). `freq_khz_o` changes only in that cycle and holds between results; it reads 0 after reset.
- R12: `start_i` is ignored while a computation is running, and inputs that change after the sampling edge do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture the inputs and begin a computation when idle |
| xtal_khz_i | input | FREQ_W | Crystal frequency, kHz |
| vco0_khz_i | input | FREQ_W | VCO 0 frequency, kHz |
| vco1_khz_i | input | FREQ_W | VCO 1 frequency, kHz |
| src_sel_i | input | 32 | Source-select word |
| div_ctl_i | input | 32 | VCO divider control word |
| pll_ctl_i | input | 32 | PLL control word (bit 0 enable) |
| pll_coef_i | input | 32 | PLL coefficient word (P, N, M) |
| pll_ref_xtal_i | input | 1 | PLL reference is the crystal, P forced to 1 |
| path_pll_i | input | 1 | Final-stage select: 1 = PLL, 0 = divider path |
| post_div_i | input | 32 | Final post-divider word |
| freq_khz_o | output | FREQ_W | Decoded frequency, kHz |
| done_o | output | 1 | One-cycle pulse when freq_khz_o is updated |

## Verification
Every result has the same latency whatever path the words select: 4·(FREQ_W+11) edges after the start edge, because each of the four division slots takes the divider's width plus two cycles. The bench derives that number from the parameter. It then compares `done_o` and `freq_khz_o` against its model on every falling edge from the start edge until two cycles past the due cycle. `done_o` must be high only in the due cycle, and `freq_khz_o` must keep the previous result until that cycle. The ignored-start case asserts `start_i` again and changes the live words in the middle of a run, and the bench checks that the due cycle and the value are unchanged.

// File: rtl/clk_rb_pkg.sv
package clk_rb_pkg;

  localparam int unsigned REG_W        = 32;
  localparam int unsigned FIELD_W      = 6;
  localparam int unsigned COEF_W       = 8;
  localparam int unsigned ALT_REF_KHZ  = 108000;
  localparam int unsigned HOST_REF_KHZ = 100000;

  typedef enum logic [1:0] {
    SRC_XTAL = 2'd0,
    SRC_OFF  = 2'd1,
    SRC_HOST = 2'd2,
    SRC_VCO  = 2'd3
  } src_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SRC,
    ST_MUL,
    ST_PDIV,
    ST_FIN
  } stage_e;

  typedef struct packed {
    src_mode_e          src_mode;
    logic               alt_ref;
    logic               vco_sel;
    logic               vdiv_en;
    logic [FIELD_W-1:0] vdiv_hi;
    logic [FIELD_W-1:0] vdiv_lo;
    logic               pll_on;
    logic [FIELD_W-1:0] pll_p;
    logic [COEF_W-1:0]  pll_n;
    logic [COEF_W-1:0]  pll_m;
    logic               ref_xtal;
    logic               path_pll;
    logic               post_en;
    logic [FIELD_W-1:0] post_hi;
    logic [FIELD_W-1:0] post_lo;
  } snap_t;

  function automatic stage_e next_stage(stage_e s);
    unique case (s)
      ST_SRC:  return ST_MUL;
      ST_MUL:  return ST_PDIV;
      ST_PDIV: return ST_FIN;
      default: return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/clk_rb_src_dec.sv
module clk_rb_src_dec
  import clk_rb_pkg::*;
#(
  parameter int unsigned FREQ_W = 32,
  parameter int unsigned NUM_W  = 41,
  parameter int unsigned DEN_W  = 8
) (
  input  src_mode_e          mode_i,
  input  logic               alt_ref_i,
  input  logic               vco_sel_i,
  input  logic               vdiv_en_i,
  input  logic [FIELD_W-1:0] vdiv_hi_i,
  input  logic [FIELD_W-1:0] vdiv_lo_i,
  input  logic [FREQ_W-1:0]  xtal_i,
  input  logic [FREQ_W-1:0]  vco0_i,
  input  logic [FREQ_W-1:0]  vco1_i,
  output logic [NUM_W-1:0]   num_o,
  output logic [DEN_W-1:0]   den_o
);

  logic [NUM_W-1:0]   base;
  logic [FIELD_W-1:0] vfld;

  assign vfld = vco_sel_i ? vdiv_hi_i : vdiv_lo_i;

  // fixed sources go through the divider as 2f/2
  always_comb begin
    base  = '0;
    den_o = DEN_W'(2);
    unique case (mode_i)
      SRC_XTAL: base = alt_ref_i ? NUM_W'(ALT_REF_KHZ) : NUM_W'(xtal_i);
      SRC_OFF:  base = '0;
      SRC_HOST: base = NUM_W'(HOST_REF_KHZ);
      SRC_VCO: begin
        base = NUM_W'(vco_sel_i ? vco1_i : vco0_i);
        if (vdiv_en_i) den_o = DEN_W'(vfld) + DEN_W'(2);
      end
      default: base = '0;
    endcase
    num_o = base << 1;
  end

endmodule

// File: rtl/clk_rb_pll_dec.sv
module clk_rb_pll_dec
  import clk_rb_pkg::*;
#(
  parameter int unsigned FREQ_W = 32,
  parameter int unsigned NUM_W  = 41,
  parameter int unsigned DEN_W  = 8
) (
  input  logic               pll_on_i,
  input  logic               ref_xtal_i,
  input  logic [COEF_W-1:0]  n_i,
  input  logic [COEF_W-1:0]  m_i,
  input  logic [FIELD_W-1:0] p_i,
  input  logic [FREQ_W-1:0]  xtal_i,
  input  logic [NUM_W-1:0]   div_ref_i,
  output logic [NUM_W-1:0]   num_o,
  output logic [DEN_W-1:0]   m_den_o,
  output logic [DEN_W-1:0]   p_den_o
);

  logic [NUM_W-1:0] ref_f;

  assign ref_f = ref_xtal_i ? NUM_W'(xtal_i) : div_ref_i;

  always_comb begin
    if (!pll_on_i) begin
      num_o   = '0;
      m_den_o = DEN_W'(1);
      p_den_o = DEN_W'(1);
    end else begin
      num_o   = ref_f * NUM_W'(n_i);
      m_den_o = DEN_W'(m_i);
      p_den_o = ref_xtal_i ? DEN_W'(1) : DEN_W'(p_i);
    end
  end

endmodule

// File: rtl/clk_rb_seq_div.sv
module clk_rb_seq_div #(
  parameter int unsigned NUM_W = 41,
  parameter int unsigned DEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic [NUM_W-1:0] quo_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam int unsigned CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] quo_q, num_q;
  logic [DEN_W-1:0] rem_q, den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q, dz_q;
  logic [DEN_W:0]   shifted, diff;
  logic             fits;

  assign shifted = {rem_q, quo_q[NUM_W-1]};
  assign fits    = shifted >= {1'b0, den_q};
  assign diff    = shifted - {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q  <= '0;
      num_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      dz_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i && !busy_q) begin
        quo_q  <= num_i;
        num_q  <= num_i;
        rem_q  <= '0;
        den_q  <= den_i;
        cnt_q  <= CNT_W'(NUM_W);
        busy_q <= 1'b1;
        dz_q   <= (den_i == '0);
      end else if (busy_q) begin
        rem_q <= fits ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
        quo_q <= {quo_q[NUM_W-2:0], fits};
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // zero divisor reads as 0
  assign quo_o  = dz_q ? '0 : quo_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  p_div_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  p_div_no_growth_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> quo_o <= num_q);

  p_div_idle_after_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);

endmodule

// File: rtl/clk_readback_decoder.sv
module clk_readback_decoder
  import clk_rb_pkg::*;
#(
  parameter int unsigned FREQ_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] xtal_khz_i,
  input  logic [FREQ_W-1:0] vco0_khz_i,
  input  logic [FREQ_W-1:0] vco1_khz_i,
  input  logic [REG_W-1:0]  src_sel_i,
  input  logic [REG_W-1:0]  div_ctl_i,
  input  logic [REG_W-1:0]  pll_ctl_i,
  input  logic [REG_W-1:0]  pll_coef_i,
  input  logic              pll_ref_xtal_i,
  input  logic              path_pll_i,
  input  logic [REG_W-1:0]  post_div_i,
  output logic [FREQ_W-1:0] freq_khz_o,
  output logic              done_o
);

  localparam int unsigned NUM_W = FREQ_W + COEF_W + 1;
  localparam int unsigned DEN_W = COEF_W;

  snap_t             snap_d, snap_q;
  logic [FREQ_W-1:0] xtal_q, vco0_q, vco1_q;
  stage_e            state_q;
  logic              go_q;
  logic [NUM_W-1:0]  acc_q;
  logic [FREQ_W-1:0] freq_q;
  logic              done_q;

  logic [NUM_W-1:0]   src_num, pll_num, div_num, div_quo;
  logic [DEN_W-1:0]   src_den, pll_m, pll_p, div_den;
  logic [FIELD_W-1:0] post_fld;
  logic               div_busy, div_done;
  logic               unused_cfg_bits;

  assign unused_cfg_bits = ^{src_sel_i[31:18], src_sel_i[15:9], src_sel_i[7:2],
                             div_ctl_i[30:14], div_ctl_i[7:6], pll_ctl_i[31:1],
                             pll_coef_i[31:22], post_div_i[30:14], post_div_i[7:6]};

  always_comb begin
    snap_d.src_mode = src_mode_e'(src_sel_i[1:0]);
    snap_d.alt_ref  = &src_sel_i[17:16];
    snap_d.vco_sel  = src_sel_i[8];
    snap_d.vdiv_en  = div_ctl_i[31];
    snap_d.vdiv_hi  = div_ctl_i[13:8];
    snap_d.vdiv_lo  = div_ctl_i[5:0];
    snap_d.pll_on   = pll_ctl_i[0];
    snap_d.pll_p    = pll_coef_i[21:16];
    snap_d.pll_n    = pll_coef_i[15:8];
    snap_d.pll_m    = pll_coef_i[7:0];
    snap_d.ref_xtal = pll_ref_xtal_i;
    snap_d.path_pll = path_pll_i;
    snap_d.post_en  = post_div_i[31];
    snap_d.post_hi  = post_div_i[13:8];
    snap_d.post_lo  = post_div_i[5:0];
  end

  clk_rb_src_dec #(.FREQ_W(FREQ_W), .NUM_W(NUM_W), .DEN_W(DEN_W)) u_src (
    .mode_i    (snap_q.src_mode),
    .alt_ref_i (snap_q.alt_ref),
    .vco_sel_i (snap_q.vco_sel),
    .vdiv_en_i (snap_q.vdiv_en),
    .vdiv_hi_i (snap_q.vdiv_hi),
    .vdiv_lo_i (snap_q.vdiv_lo),
    .xtal_i    (xtal_q),
    .vco0_i    (vco0_q),
    .vco1_i    (vco1_q),
    .num_o     (src_num),
    .den_o     (src_den)
  );

  // acc_q holds the decoded source while the PLL stages run
  clk_rb_pll_dec #(.FREQ_W(FREQ_W), .NUM_W(NUM_W), .DEN_W(DEN_W)) u_pll (
    .pll_on_i   (snap_q.pll_on),
    .ref_xtal_i (snap_q.ref_xtal),
    .n_i        (snap_q.pll_n),
    .m_i        (snap_q.pll_m),
    .p_i        (snap_q.pll_p),
    .xtal_i     (xtal_q),
    .div_ref_i  (acc_q),
    .num_o      (pll_num),
    .m_den_o    (pll_m),
    .p_den_o    (pll_p)
  );

  assign post_fld = snap_q.path_pll ? snap_q.post_hi : snap_q.post_lo;

  always_comb begin
    div_num = acc_q;
    div_den = DEN_W'(1);
    unique case (state_q)
      ST_SRC: begin
        div_num = src_num;
        div_den = src_den;
      end
      ST_MUL: if (snap_q.path_pll) begin
        div_num = pll_num;
        div_den = pll_m;
      end
      ST_PDIV: if (snap_q.path_pll) div_den = pll_p;
      ST_FIN: if (snap_q.post_en) begin
        div_num = acc_q << 1;
        div_den = DEN_W'(post_fld) + DEN_W'(2);
      end
      default: ;
    endcase
  end

  clk_rb_seq_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go_q),
    .num_i  (div_num),
    .den_i  (div_den),
    .quo_o  (div_quo),
    .busy_o (div_busy),
    .done_o (div_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q  <= '0;
      xtal_q  <= '0;
      vco0_q  <= '0;
      vco1_q  <= '0;
      state_q <= ST_IDLE;
      go_q    <= 1'b0;
      acc_q   <= '0;
      freq_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (start_i) begin
          snap_q  <= snap_d;
          xtal_q  <= xtal_khz_i;
          vco0_q  <= vco0_khz_i;
          vco1_q  <= vco1_khz_i;
          state_q <= ST_SRC;
          go_q    <= 1'b1;
        end
      end else if (div_done) begin
        acc_q   <= div_quo;
        state_q <= next_stage(state_q);
        if (state_q == ST_FIN) begin
          freq_q <= div_quo[FREQ_W-1:0];
          done_q <= 1'b1;
        end else begin
          go_q <= 1'b1;
        end
      end
    end
  end

  assign freq_khz_o = freq_q;
  assign done_o     = done_q;

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  p_result_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_q |-> $stable(freq_q));

  p_go_when_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_q |-> !div_busy);

  p_busy_start_ignored_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && start_i && !div_done) |=> state_q == $past(state_q));

  p_done_from_fin_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> state_q == ST_IDLE);

endmodule

// File: tb/clk_readback_decoder_bench.sv
`timescale 1ns/1ps
module clk_readback_decoder_bench;

  localparam int FW  = 32;
  localparam int LAT = 4 * (FW + 11);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [FW-1:0] xtal, vco0, vco1;
  logic [31:0]   src, dctl, pctl, coef, post;
  logic          ref_x, path_pll;
  logic [FW-1:0] freq;
  logic          done;

  int            tests = 0;
  int            fails = 0;
  logic [FW-1:0] held = '0;

  always #2 clk = ~clk;

  clk_readback_decoder #(.FREQ_W(FW)) u_clk_readback_decoder (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .start_i        (start),
    .xtal_khz_i     (xtal),
    .vco0_khz_i     (vco0),
    .vco1_khz_i     (vco1),
    .src_sel_i      (src),
    .div_ctl_i      (dctl),
    .pll_ctl_i      (pctl),
    .pll_coef_i     (coef),
    .pll_ref_xtal_i (ref_x),
    .path_pll_i     (path_pll),
    .post_div_i     (post),
    .freq_khz_o     (freq),
    .done_o         (done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] model();
    longint unsigned fs, f, d, fld, rf, n, m, p, v;
    case (src[1:0])
      2'd0: fs = (src[17:16] == 2'b11) ? 64'd108000 : 64'(xtal);
      2'd1: fs = 0;
      2'd2: fs = 64'd100000;
      default: begin
        v  = src[8] ? 64'(vco1) : 64'(vco0);
        d  = dctl[31] ? (64'(src[8] ? dctl[13:8] : dctl[5:0]) + 2) : 64'd2;
        fs = v * 2 / d;
      end
    endcase
    if (path_pll) begin
      if (!pctl[0]) f = 0;
      else begin
        rf = ref_x ? 64'(xtal) : fs;
        n  = 64'(coef[15:8]);
        m  = 64'(coef[7:0]);
        p  = ref_x ? 64'd1 : 64'(coef[21:16]);
        if (m == 0 || p == 0) f = 0;
        else f = rf * n / m / p;
      end
    end else f = fs;
    fld = path_pll ? 64'(post[13:8]) : 64'(post[5:0]);
    if (post[31]) f = f * 2 / (fld + 2);
    return f[FW-1:0];
  endfunction

  task automatic cfg(input logic [31:0] s, input logic [31:0] dc, input logic [31:0] pc,
                     input logic [31:0] cf, input logic rx, input logic pp,
                     input logic [31:0] pd);
    xtal = 27000; vco0 = 1620000; vco1 = 2000000;
    src = s; dctl = dc; pctl = pc; coef = cf; ref_x = rx; path_pll = pp; post = pd;
  endtask

  // every falling edge from the start edge to LAT+2 is compared to the model
  task automatic run(input string req, input bit poke);
    logic [FW-1:0]   exp, exp_f;
    longint unsigned bad_t, bad_act, bad_exp;
    bit              t_ok, v_ok;
    exp  = model();
    t_ok = 1; v_ok = 1; bad_t = 0; bad_act = 0; bad_exp = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int n = 0; n <= LAT + 2; n++) begin
      if (n > 0) @(negedge clk);
      if (poke && n == 10) begin
        start = 1'b1; src = 32'h2; post = 32'h8000_0000; xtal = 1;
      end
      if (poke && n == 11) start = 1'b0;
      exp_f = (n >= LAT) ? exp : held;
      if (t_ok && (done !== (n == LAT))) begin t_ok = 0; bad_t = longint'(n); end
      if (v_ok && (freq !== exp_f)) begin v_ok = 0; bad_act = freq; bad_exp = exp_f; end
    end
    check(t_ok, req, "done pulse cycle (first wrong)", t_ok ? LAT : bad_t, LAT);
    check(v_ok, req, "freq_khz_o", v_ok ? exp : bad_act, v_ok ? exp : bad_exp);
    held = exp;
  endtask

  initial begin
    cfg(0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check(freq === '0, "R11", "freq in reset", freq, 0);
    check(done === 1'b0, "R11", "done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(freq === '0 && done === 1'b0, "R11", "idle after reset", freq, 0);

    cfg(32'h0, 0, 0, 0, 0, 0, 0);                       run("R2 crystal", 0);
    cfg(32'h0003_0000, 0, 0, 0, 0, 0, 0);               run("R2 alt ref", 0);
    cfg(32'h0001_0000, 0, 0, 0, 0, 0, 0); xtal = 25000; run("R2 one bit", 0);
    cfg(32'h2, 0, 0, 0, 0, 0, 0);                       run("R3 host ref", 0);
    cfg(32'h1, 0, 0, 0, 0, 0, 0);                       run("R3 off", 0);
    cfg(32'h3, 0, 0, 0, 0, 0, 0);                       run("R4 vco0 default", 0);
    cfg(32'h103, 32'h0000_0A05, 0, 0, 0, 0, 0);         run("R4 vco1 ctl off", 0);
    cfg(32'h103, 32'h8000_0A05, 0, 0, 0, 0, 0);         run("R5 high field", 0);
    cfg(32'h3, 32'h8000_0A05, 0, 0, 0, 0, 0);           run("R5 low field", 0);
    cfg(32'h2, 0, 32'h0, 32'h0002_1004, 0, 1, 32'h8000_0000); run("R1 pll off", 0);
    cfg(32'h2, 0, 32'h1, 32'h0005_4001, 1, 1, 0);       run("R8 crystal ref", 0);
    cfg(32'h2, 0, 32'h1, 32'h0002_2004, 0, 1, 0);       run("R7 source ref", 0);
    cfg(32'h0, 0, 32'h1, 32'h0003_0A07, 0, 1, 0);       run("R7 truncation", 0);
    cfg(32'h2, 0, 32'h1, 32'h0002_2000, 0, 1, 0);       run("R9 M zero", 0);
    cfg(32'h2, 0, 32'h1, 32'h0000_2004, 0, 1, 0);       run("R9 P zero", 0);
    cfg(32'h2, 0, 32'h1, 32'h0000_2004, 1, 1, 0);       run("R8 P forced", 0);
    cfg(32'h2, 0, 0, 0, 0, 0, 32'h8000_3F03);           run("R6 low field", 0);
    cfg(32'h2, 0, 32'h1, 32'h0000_0101, 1, 1, 32'h8000_0603); run("R6 high field", 0);
    cfg(32'h2, 0, 0, 0, 0, 0, 32'h0000_3F3F);           run("R10 bypass", 0);
    cfg(32'h2, 0, 0, 0, 0, 0, 32'h8000_003F);           run("R10 max field", 0);
    cfg(32'h103, 32'h8000_0A05, 0, 0, 0, 0, 0);         run("R12 start while busy", 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule